// File: doc/BRIEF.md
# Instruction-driven SPI sequencer

This block is an SPI bus master that runs a small program, not a fixed shift triggered by a register write. It fetches 16-bit instructions one at a time from a command stream. Each instruction starts a data transfer, updates the chip selects, writes the clock divider or the bus mode, waits for a number of SCLK periods, or emits a sync marker. Transmit words come from an input stream and received words leave through an output stream. All three streams use a ready/valid handshake.

A host builds a short program for each message. It selects the mode and the divider, asserts a chip select, moves data, sleeps if the slave needs a gap, releases the chip select and ends with a sync. The sync pulse tells the host that every instruction before it has finished. The block waits instead of breaking a word when the transmit stream runs dry or the receive stream is full. The bus then idles between words, and no bit is lost.

Top module: `spi_seq_core`

## Requirements
- R1: An instruction holds an opcode in bits 15:12, a small argument in bits 11:8 and a byte argument in bits 7:0. Instructions are accepted one at a time, only while the core is idle. An opcode above 3, a register write with small argument above 1, and opcode 3 with small argument above 1 are each accepted and have no effect.
- R2: Opcode 0 moves (byte argument + 1) words, from 1 to 256, MSB first. Small-argument bit 0 takes one word from the transmit stream per word shifted. Small-argument bit 1 hands each received word to the receive stream.
- R3: In a transfer with bit 0 clear, SDO is driven low for every bit. In a transfer with bit 1 clear, no received word is handed out.
- R4: Opcode 1 loads the byte argument onto the active-low chip-select lines, one bit per line, after a delay of (small argument) SCLK periods. The lines keep their old value until the delay ends, and with a zero delay they change the cycle after acceptance.
- R5: Opcode 2 with small argument 0 loads the divider from the byte argument. Every SCLK half period then lasts (divider + 1) clock cycles.
- R6: Opcode 2 with small argument 1 loads the mode from the byte argument. Bit 0 selects the phase and bit 1 selects the idle level of SCLK. With phase 0, data is sampled on the leading edge and set up before it. With phase 1, data is driven on the leading edge and sampled on the trailing edge.
- R7: Mode bit 2 selects 3-wire operation. The SDO enable is then low during transfers whose bit 0 is clear. It is high at all other times.
- R8: Opcode 3 with small argument 1 sleeps for (byte argument + 1) SCLK periods. SCLK and the chip selects do not move during the sleep, and the next instruction is accepted only once it is over.
- R9: Opcode 3 with small argument 0 raises the sync pulse for one cycle, the cycle after the instruction is accepted, with the byte argument on the sync ID. It is accepted only after all earlier instructions have finished.
- R10: When the transmit stream is empty or the receive stream is not ready, SCLK holds its idle level between words. The data shifted afterwards is unchanged.
- R11: After reset every chip select is high, the divider is 0 and the mode is 0. The sync pulse and the receive valid are low, and the core is ready for an instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Instruction valid |
| cmd_ready_o | output | 1 | Core accepts an instruction |
| cmd_data_i | input | 16 | Instruction word |
| tx_valid_i | input | 1 | Transmit word valid |
| tx_ready_o | output | 1 | Core takes the transmit word |
| tx_data_i | input | WORD_W | Transmit word |
| rx_valid_o | output | 1 | Received word valid |
| rx_ready_i | input | 1 | Consumer takes the received word |
| rx_data_o | output | WORD_W | Received word |
| sclk_o | output | 1 | SPI clock |
| sdo_o | output | 1 | Serial data out |
| sdo_en_o | output | 1 | Output enable for SDO |
| sdi_i | input | 1 | Serial data in |
| cs_n_o | output | NUM_CS | Chip selects, active low |
| sync_o | output | 1 | Sync pulse |
| sync_id_o | output | 8 | ID of the last sync |

## Verification
The bench uses the defaults of eight chip selects, 8-bit words and an 8-bit divider. It programs divider values from 0 to 3, so every SCLK phase, sleep and chip-select delay spans at most a few dozen cycles. That keeps a full 256-word transfer, all four modes with and without 3-wire operation, and counted sleep and delay windows inside a short run. Holding the transmit and receive streams shows the stall between words without waiting long.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;

  localparam logic [3:0] OP_XFER = 4'h0;
  localparam logic [3:0] OP_CS   = 4'h1;
  localparam logic [3:0] OP_WREG = 4'h2;
  localparam logic [3:0] OP_MISC = 4'h3;

  localparam logic [3:0] REG_DIV    = 4'h0;
  localparam logic [3:0] REG_CFG    = 4'h1;
  localparam logic [3:0] MISC_SYNC  = 4'h0;
  localparam logic [3:0] MISC_SLEEP = 4'h1;

  typedef struct packed {
    logic [3:0] op;
    logic [3:0] a1;
    logic [7:0] a2;
  } instr_t;

  typedef struct packed {
    logic three_wire;
    logic cpol;
    logic cpha;
  } cfg_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOAD, ST_SHIFT, ST_PUSH, ST_CSWAIT, ST_SLEEP
  } state_e;

endpackage

// File: rtl/spi_seq_tick.sv
module spi_seq_tick #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);

  logic [DIV_W-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!en_i || tick_o)   cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  // a half period is never shorter than div+1 cycles
  assert_half_period_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && div_i != '0) |=> !tick_o);

endmodule

// File: rtl/spi_seq_shift.sv
module spi_seq_shift #(
  parameter int unsigned WORD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] tx_word_i,
  input  logic              tick_i,
  input  logic              cpha_i,
  input  logic              cpol_i,
  input  logic              sdi_i,
  output logic              sclk_o,
  output logic              sdo_o,
  output logic [WORD_W-1:0] rx_word_o,
  output logic              done_o
);

  localparam int unsigned EDGE_W    = $clog2(2 * WORD_W);
  localparam int unsigned LAST_EDGE = 2 * WORD_W - 1;

  logic [EDGE_W-1:0] edge_q;
  logic              phase_q, out_q;
  logic [WORD_W-1:0] sh_q, rx_q;
  logic              leading;

  assign leading   = !edge_q[0];
  assign done_o    = tick_i && (edge_q == EDGE_W'(LAST_EDGE));
  assign sclk_o    = phase_q ^ cpol_i;
  assign sdo_o     = out_q;
  assign rx_word_o = rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      edge_q  <= '0;
      phase_q <= 1'b0;
      out_q   <= 1'b0;
      sh_q    <= '0;
      rx_q    <= '0;
    end else if (load_i) begin
      edge_q  <= '0;
      phase_q <= 1'b0;
      out_q   <= tx_word_i[WORD_W-1];
      sh_q    <= cpha_i ? tx_word_i : {tx_word_i[WORD_W-2:0], 1'b0};
    end else if (tick_i) begin
      phase_q <= !phase_q;
      edge_q  <= edge_q + 1'b1;
      if (leading == cpha_i) begin
        // drive edge
        out_q <= sh_q[WORD_W-1];
        sh_q  <= {sh_q[WORD_W-2:0], 1'b0};
      end else begin
        // sample edge
        rx_q <= {rx_q[WORD_W-2:0], sdi_i};
      end
    end
  end

  assert_rx_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !load_i) |=> $stable(rx_word_o));

endmodule

// File: rtl/spi_seq_core.sv
module spi_seq_core
  import spi_seq_pkg::*;
#(
  parameter int unsigned NUM_CS = 8,
  parameter int unsigned WORD_W = 8,
  parameter int unsigned DIV_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic [15:0]       cmd_data_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  input  logic [WORD_W-1:0] tx_data_i,
  output logic              rx_valid_o,
  input  logic              rx_ready_i,
  output logic [WORD_W-1:0] rx_data_o,
  output logic              sclk_o,
  output logic              sdo_o,
  output logic              sdo_en_o,
  input  logic              sdi_i,
  output logic [NUM_CS-1:0] cs_n_o,
  output logic              sync_o,
  output logic [7:0]        sync_id_o
);

  localparam int unsigned WAIT_W = 10;

  instr_t            ins;
  state_e            state_q;
  logic              wr_q, rd_q;
  logic [7:0]        words_q;
  logic [WAIT_W-1:0] wait_q, sleep_ticks, cs_ticks;
  logic [NUM_CS-1:0] cs_q, cs_pend_q;
  logic [DIV_W-1:0]  div_q;
  cfg_t              cfg_q;
  logic              sync_q;
  logic [7:0]        sync_id_q;
  logic              fire, tick, shift_tick, load, done, div_en, wait_done, xfer_st;
  logic [WORD_W-1:0] tx_word, rx_word;

  assign ins         = instr_t'(cmd_data_i);
  assign cmd_ready_o = (state_q == ST_IDLE);
  assign fire        = cmd_valid_i && cmd_ready_o;
  assign div_en      = (state_q == ST_SHIFT) || (state_q == ST_SLEEP) || (state_q == ST_CSWAIT);
  assign shift_tick  = tick && (state_q == ST_SHIFT);
  assign tx_ready_o  = (state_q == ST_LOAD) && wr_q;
  assign load        = (state_q == ST_LOAD) && (!wr_q || tx_valid_i);
  assign tx_word     = wr_q ? tx_data_i : '0;
  assign wait_done   = tick && (wait_q == WAIT_W'(1));
  assign rx_valid_o  = (state_q == ST_PUSH);
  assign rx_data_o   = rx_word;
  assign xfer_st     = (state_q == ST_LOAD) || (state_q == ST_SHIFT) || (state_q == ST_PUSH);
  assign sdo_en_o    = !(cfg_q.three_wire && !wr_q && xfer_st);
  assign cs_n_o      = cs_q;
  assign sync_o      = sync_q;
  assign sync_id_o   = sync_id_q;
  assign sleep_ticks = (WAIT_W'(ins.a2) + WAIT_W'(1)) << 1;
  assign cs_ticks    = WAIT_W'(ins.a1) << 1;

  spi_seq_tick #(.DIV_W(DIV_W)) i_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (div_en),
    .div_i  (div_q),
    .tick_o (tick)
  );

  spi_seq_shift #(.WORD_W(WORD_W)) i_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .tx_word_i (tx_word),
    .tick_i    (shift_tick),
    .cpha_i    (cfg_q.cpha),
    .cpol_i    (cfg_q.cpol),
    .sdi_i     (sdi_i),
    .sclk_o    (sclk_o),
    .sdo_o     (sdo_o),
    .rx_word_o (rx_word),
    .done_o    (done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      wr_q      <= 1'b0;
      rd_q      <= 1'b0;
      words_q   <= '0;
      wait_q    <= '0;
      cs_q      <= '1;
      cs_pend_q <= '1;
      div_q     <= '0;
      cfg_q     <= '0;
      sync_q    <= 1'b0;
      sync_id_q <= '0;
    end else begin
      sync_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (fire) begin
          case (ins.op)
            OP_XFER: begin
              wr_q    <= ins.a1[0];
              rd_q    <= ins.a1[1];
              words_q <= ins.a2;
              state_q <= ST_LOAD;
            end
            OP_CS: begin
              if (ins.a1 == '0) cs_q <= ins.a2[NUM_CS-1:0];
              else begin
                cs_pend_q <= ins.a2[NUM_CS-1:0];
                wait_q    <= cs_ticks;
                state_q   <= ST_CSWAIT;
              end
            end
            OP_WREG: begin
              if (ins.a1 == REG_DIV)      div_q <= DIV_W'(ins.a2);
              else if (ins.a1 == REG_CFG) cfg_q <= cfg_t'(ins.a2[2:0]);
            end
            OP_MISC: begin
              if (ins.a1 == MISC_SLEEP) begin
                wait_q  <= sleep_ticks;
                state_q <= ST_SLEEP;
              end else if (ins.a1 == MISC_SYNC) begin
                sync_q    <= 1'b1;
                sync_id_q <= ins.a2;
              end
            end
            default: ;
          endcase
        end
        ST_LOAD: if (load) state_q <= ST_SHIFT;
        ST_SHIFT: if (done) begin
          if (rd_q)                  state_q <= ST_PUSH;
          else if (words_q == '0)    state_q <= ST_IDLE;
          else begin
            words_q <= words_q - 1'b1;
            state_q <= ST_LOAD;
          end
        end
        ST_PUSH: if (rx_ready_i) begin
          if (words_q == '0) state_q <= ST_IDLE;
          else begin
            words_q <= words_q - 1'b1;
            state_q <= ST_LOAD;
          end
        end
        ST_CSWAIT: begin
          if (wait_done) begin
            cs_q    <= cs_pend_q;
            state_q <= ST_IDLE;
          end else if (tick) wait_q <= wait_q - 1'b1;
        end
        ST_SLEEP: begin
          if (wait_done)  state_q <= ST_IDLE;
          else if (tick)  wait_q <= wait_q - 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_sleep_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SLEEP) |=> ($stable(cs_n_o) && $stable(sclk_o)));

  assert_sync_origin_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_o |-> ($past(fire && ins.op == OP_MISC && ins.a1 == MISC_SYNC) &&
                sync_id_o == $past(ins.a2)));

  assert_rx_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_o && !rx_ready_i) |=> (rx_valid_o && $stable(rx_data_o)));

  assert_sdo_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SHIFT && !wr_q) |-> !sdo_o);

  assert_idle_level_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> (sclk_o == cfg_q.cpol));

endmodule

// File: tb/test_spi_seq_core.sv
module test_spi_seq_core;

  localparam int unsigned SEED = 32'h5A17_0C3D;
  localparam int MEM = 300;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [15:0] cmd_data = '0;
  logic       cmd_ready;
  logic       tx_valid = 1'b0;
  logic [7:0] tx_data = '0;
  logic       tx_ready;
  logic       rx_valid;
  logic       rx_ready = 1'b0;
  logic [7:0] rx_data;
  logic       sclk, sdo, sdo_en, sdi, sync;
  logic [7:0] cs_n, sync_id;

  always #5 clk = ~clk;

  spi_seq_core i_spi_seq_core (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready), .cmd_data_i(cmd_data),
    .tx_valid_i(tx_valid), .tx_ready_o(tx_ready), .tx_data_i(tx_data),
    .rx_valid_o(rx_valid), .rx_ready_i(rx_ready), .rx_data_o(rx_data),
    .sclk_o(sclk), .sdo_o(sdo), .sdo_en_o(sdo_en), .sdi_i(sdi),
    .cs_n_o(cs_n), .sync_o(sync), .sync_id_o(sync_id)
  );

  int chk = 0, fail = 0;
  logic [7:0] tx_mem [0:MEM-1];
  logic [7:0] rx_mem [0:MEM-1];
  logic [7:0] sl_out [0:MEM-1];
  logic [7:0] sl_in  [0:MEM-1];
  int tx_n = 0, tx_rd = 0, rx_n = 0, sl_oidx = 0, sl_ibits = 0;
  int n_edges = 0, min_gap = 1000000, last_edge = 0, cyc = 0;
  int sync_cnt = 0, sync_edges = -1;
  logic [7:0] sync_last = '0, sl_acc = '0;
  bit tx_hold = 0, rx_hold = 0, tx_hs = 0, mon_on = 0, saw_en_low = 0;
  bit cur_cpol = 0, cur_cpha = 0;
  logic prev_sclk = 1'b0;

  assign sdi = sl_out[(sl_oidx / 8) % MEM][7 - (sl_oidx % 8)];

  // slave model, stream endpoints and monitors, all at the falling edge
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (!mon_on) prev_sclk = sclk;
      else if (sclk != prev_sclk) begin
        bit lead;
        n_edges++;
        if (cyc - last_edge < min_gap) min_gap = cyc - last_edge;
        last_edge = cyc;
        lead = (sclk != cur_cpol);
        if (lead == !cur_cpha) begin
          sl_acc = {sl_acc[6:0], sdo};
          sl_ibits++;
          if (sl_ibits % 8 == 0 && sl_ibits / 8 <= MEM) sl_in[sl_ibits / 8 - 1] = sl_acc;
        end
        if (!lead) sl_oidx++;
        prev_sclk = sclk;
      end
      if (!sdo_en) saw_en_low = 1;
      if (sync) begin
        sync_cnt++;
        sync_last = sync_id;
        sync_edges = n_edges;
      end
      if (tx_hs) tx_rd++;
      tx_valid = (tx_rd < tx_n) && !tx_hold;
      tx_data = tx_mem[tx_rd % MEM];
      tx_hs = tx_valid && tx_ready;
      rx_ready = !rx_hold;
      if (rx_valid && rx_ready && rx_n < MEM) begin
        rx_mem[rx_n] = rx_data;
        rx_n++;
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    chk++;
    if (act !== exp) begin
      fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic push_cmd(input logic [15:0] w);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_data = w;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (!cmd_ready);
    @(negedge clk);
  endtask

  task automatic set_mode(input bit cpha, input bit cpol, input bit tw, input int div);
    mon_on = 0;
    push_cmd({4'h2, 4'h1, 5'd0, tw, cpol, cpha});
    push_cmd({4'h2, 4'h0, 8'(div)});
    cur_cpha = cpha;
    cur_cpol = cpol;
    @(negedge clk);
    @(negedge clk);
    mon_on = 1;
  endtask

  task automatic prepare(input int n);
    for (int i = 0; i < MEM; i++) begin
      tx_mem[i] = 8'($urandom);
      sl_out[i] = 8'($urandom);
      sl_in[i]  = 8'hxx;
    end
    sl_oidx = 0; sl_ibits = 0; tx_rd = 0; rx_n = 0; tx_hs = 0;
    n_edges = 0; min_gap = 1000000; last_edge = cyc; saw_en_low = 0;
    tx_n = n;
  endtask

  task automatic check_xfer(input int n, input bit wr, input bit rd, input int div);
    int bad = 0;
    for (int i = 0; i < n; i++) if (sl_in[i] !== (wr ? tx_mem[i] : 8'h00)) bad++;
    check(wr ? "R2 R6 words seen by slave" : "R3 sdo low when write flag clear", bad, 0);
    bad = 0;
    if (rd) for (int i = 0; i < n; i++) if (rx_mem[i] !== sl_out[i]) bad++;
    check("R2 R6 received words", bad, 0);
    check(rd ? "R2 rx word count" : "R3 nothing handed out when read flag clear", rx_n, rd ? n : 0);
    check("R2 tx words taken", tx_rd, wr ? n : 0);
    check("R5 sclk edge count", n_edges, 16 * n);
    check("R5 half period", min_gap, div + 1);
    check("R6 sclk idle level", int'(sclk), int'(cur_cpol));
  endtask

  task automatic run_xfer(input int n, input bit wr, input bit rd, input int div);
    prepare(n);
    push_cmd({4'h0, 2'b00, rd, wr, 8'(n - 1)});
    wait_idle();
    check_xfer(n, wr, rd, div);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", chk, fail);
    $finish;
  end

  initial begin
    int cnt;
    bit moved;
    logic [7:0] cs_before;
    int sc;
    void'($urandom(SEED));
    for (int i = 0; i < MEM; i++) begin sl_out[i] = '0; tx_mem[i] = '0; end
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 chip selects high", int'(cs_n), 8'hFF);
    check("R11 sclk idle low", int'(sclk), 0);
    check("R11 rx valid low", int'(rx_valid), 0);
    check("R11 sync low", int'(sync), 0);
    check("R11 ready for instruction", int'(cmd_ready), 1);
    check("R11 sdo enabled", int'(sdo_en), 1);
    rst_n = 1'b1;
    @(negedge clk);
    mon_on = 1;

    // R4 immediate chip select
    push_cmd({4'h1, 4'h0, 8'hFE});
    check("R4 immediate chip select", int'(cs_n), 8'hFE);

    // R11 default divider and mode
    run_xfer(3, 1, 1, 0);
    check("R11 default mode idle low", int'(sclk), 0);

    // R6 all four modes
    for (int m = 0; m < 4; m++) begin
      set_mode(m[0], m[1], 0, m);
      run_xfer(2 + m, 1, 1, m);
    end

    // R7 3-wire
    set_mode(0, 0, 1, 1);
    run_xfer(2, 0, 1, 1);
    check("R7 sdo released on read-only", int'(saw_en_low), 1);
    run_xfer(2, 1, 1, 1);
    check("R7 sdo kept on write", int'(saw_en_low), 0);
    set_mode(0, 0, 0, 1);
    run_xfer(2, 0, 1, 1);
    check("R7 sdo kept in 4-wire mode", int'(saw_en_low), 0);

    // R3 write-only
    run_xfer(2, 1, 0, 1);

    // R8 sleep: 4 periods at divider 2
    set_mode(1, 1, 0, 2);
    n_edges = 0;
    cs_before = cs_n;
    moved = 0;
    push_cmd({4'h3, 4'h1, 8'd3});
    cnt = 0;
    while (!cmd_ready) begin
      cnt++;
      if (cs_n !== cs_before) moved = 1;
      @(negedge clk);
    end
    check("R8 sleep length", cnt, 24);
    check("R8 chip selects held", int'(moved), 0);
    check("R8 sclk held", n_edges, 0);

    // R4 delayed chip select: 3 periods at divider 1
    set_mode(0, 0, 0, 1);
    cs_before = cs_n;
    moved = 0;
    push_cmd({4'h1, 4'h3, 8'hF7});
    cnt = 0;
    while (!cmd_ready) begin
      cnt++;
      if (cs_n !== cs_before) moved = 1;
      @(negedge clk);
    end
    check("R4 delay length", cnt, 12);
    check("R4 old mask during delay", int'(moved), 0);
    check("R4 new mask after delay", int'(cs_n), 8'hF7);

    // R1 ignored encodings
    sc = sync_cnt;
    push_cmd(16'h5123);
    push_cmd(16'h3277);
    push_cmd(16'h23FF);
    check("R1 unknown opcodes keep chip selects", int'(cs_n), 8'hF7);
    check("R1 unknown opcodes no sync", sync_cnt, sc);
    check("R1 ready after unknown opcode", int'(cmd_ready), 1);
    check("R1 mode unchanged", int'(sclk), 0);
    run_xfer(2, 1, 1, 1);

    // R9 sync after a transfer
    prepare(2);
    sc = sync_cnt;
    push_cmd({4'h0, 4'h3, 8'd1});
    push_cmd({4'h3, 4'h0, 8'h5A});
    @(negedge clk);
    @(negedge clk);
    check("R9 one sync pulse", sync_cnt, sc + 1);
    check("R9 sync id", int'(sync_last), 8'h5A);
    check("R9 sync after earlier transfer", sync_edges, 32);

    // R10 transmit stall
    prepare(2);
    tx_hold = 1;
    push_cmd({4'h0, 4'h3, 8'd1});
    repeat (40) @(negedge clk);
    check("R10 sclk idle while tx empty", n_edges, 0);
    tx_hold = 0;
    wait_idle();
    check_xfer(2, 1, 1, 1);

    // R10 receive stall
    prepare(2);
    rx_hold = 1;
    push_cmd({4'h0, 4'h3, 8'd1});
    repeat (80) @(negedge clk);
    check("R10 sclk stops after first word", n_edges, 16);
    check("R10 nothing received while held", rx_n, 0);
    rx_hold = 0;
    wait_idle();
    check_xfer(2, 1, 1, 1);

    // R2 longest transfer
    set_mode(0, 0, 0, 0);
    run_xfer(256, 1, 1, 0);

    // random mix
    for (int it = 0; it < 10; it++) begin
      int m, d, n;
      bit wr, rd;
      m = int'($urandom % 8);
      d = int'($urandom % 4);
      n = 1 + int'($urandom % 4);
      wr = 1'($urandom);
      rd = 1'($urandom);
      set_mode(m[0], m[1], m[2], d);
      run_xfer(n, wr, rd, d);
      check("R7 enable matches mode", int'(saw_en_low), int'(m[2] && !wr));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", chk, fail);
    $finish;
  end

endmodule